// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block serialises one parallel character per handshake onto a single line. Each frame has the following parts:

- a low start bit;
- 5 to 9 data bits, least significant bit first;
- an optional even or odd parity bit;
- one or two high stop bits.

The character length, parity mode, stop count, bit rate, mode and clock polarity are all chosen at run time through configuration inputs. The block samples them once, at the moment a character is accepted.

In asynchronous mode, every bit is held for a fixed number of system clock cycles. That number is set by a programmable divider. In synchronous mode, the block also drives a shift clock. That clock makes one full cycle per bit, and its edge polarity can be selected, so that a receiver can sample on the opposite edge from the one where data changes.

A character is offered on a valid/ready port. The port accepts a new character while the line is idle, and also in the very last cycle of the final stop bit. Accepting in that last cycle lets a continuous stream leave with no idle gap between frames.

Top module: `ser_frame_tx`

## Requirements
- R1: A frame starts with one start bit driven low on `txd_o`. It appears in the cycle after the handshake.
- R2: `len_code_i` selects the data length as code+5. Codes 0..4 give 5..9 bits, and codes 5..7 also give 9 bits. Data bits follow the start bit, bit 0 first.
- R3: `parity_i` 1 selects even parity and 2 selects odd parity; 0 and 3 send no parity bit. The parity bit follows the last data bit. Only the configured data bits are counted, and the bit makes the total number of ones even (mode 1) or odd (mode 2).
- R4: `stop2_i` 0 sends one high stop bit and 1 sends two. They come after data and parity.
- R5: With nothing accepted, `txd_o` rests high. A character accepted during the final stop bit starts its start bit in the very next cycle.
- R6: `tx_ready_o` is high while no frame is in progress, and in the last clock cycle of the final stop bit. It is low at every other cycle of a frame. A character is taken when `tx_valid_i` and `tx_ready_o` are both high at a clock edge.
- R7: Every bit lasts exactly 2*(`div_i`+1) clock cycles. The divider value is sampled when the frame is accepted.
- R8: Changes on any configuration input or on `div_i` after acceptance do not alter the frame in progress.
- R9: In synchronous mode (`sync_mode_i`=1), `sclk_o` is at the inverse of the polarity for the first half of each bit and at the polarity for the second half. With polarity 0, data therefore changes on the rising edge; with polarity 1, on the falling edge.
- R10: `sclk_o` equals `sclk_pol_i` while idle. In asynchronous mode it stays at the latched polarity throughout a frame.
- R11: `busy_o` is high from the cycle after acceptance until the end of the last stop bit. It is low after a frame when no back-to-back character was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Half-bit length minus one, in clock cycles |
| sync_mode_i | input | 1 | 1 = synchronous mode with shift clock |
| sclk_pol_i | input | 1 | Shift clock polarity and rest level |
| len_code_i | input | 3 | Data length code (length = code+5, max 9) |
| parity_i | input | 2 | 0/3 none, 1 even, 2 odd |
| stop2_i | input | 1 | 1 = two stop bits |
| tx_valid_i | input | 1 | Character offered |
| tx_data_i | input | DATA_W | Character, bit 0 sent first |
| tx_ready_o | output | 1 | Character can be taken this cycle |
| txd_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Shift clock for synchronous mode |
| busy_o | output | 1 | Frame in progress |

## Verification
The embedded assertions run on every cycle and cover the following:

- the idle line stays high;
- a start bit follows each acceptance;
- the latched configuration stays stable mid-frame;
- `txd_o` changes only at bit boundaries;
- the divider counter stays in range;
- in synchronous mode, every data transition lines up with the shift clock moving to its change level.

Only the bench scenarios can show the exact bit sequence of each format, the correct parity value, and the precise bit length for a given divider. The same holds for the absence of a gap between back-to-back frames and for immunity to configuration changes made mid-frame. The bench shows these by comparing each cycle of each frame against an expected frame built from the requirements.

// File: rtl/ser_frame_pkg.sv
package ser_frame_pkg;

  localparam int unsigned MIN_LEN = 5;
  localparam int unsigned LEN_CW  = 3;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_NONE3 = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic              sync;
    logic              pol;
    logic [LEN_CW-1:0] len;
    par_mode_e         par;
    logic              stop2;
  } tx_cfg_t;

endpackage

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             half_o,
  output logic             bit_end_o
);

  logic [DIV_W-1:0] cnt_q, div_q;
  logic             half_q;
  logic             wrap;

  assign wrap = (cnt_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= '0;
      half_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      div_q  <= div_i;
      half_q <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        half_q <= ~half_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end
  end

  assign half_o    = half_q;
  assign bit_end_o = run_i & half_q & wrap;

  // R7: counter never runs past the latched divider
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_q));

endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq
  import ser_frame_pkg::*;
#(
  parameter int unsigned DATA_W  = 9,
  parameter int unsigned FRAME_W = DATA_W + 4,
  parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  tx_cfg_t           cfg_i,
  input  logic              bit_end_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              last_o,
  output logic              sync_q_o,
  output logic              pol_q_o
);

  localparam int unsigned LW = $clog2(DATA_W + 1);
  localparam logic [LEN_CW-1:0] LEN_TOP = LEN_CW'(DATA_W - MIN_LEN);

  logic [LW-1:0]      nd;
  logic               par_en, par_bit;
  logic [FRAME_W-1:0] frame_n, frame_q;
  logic [CNT_W-1:0]   nbits, left_q;
  logic               busy_q;
  tx_cfg_t            cfg_q;

  always_comb begin
    if (cfg_i.len >= LEN_TOP) nd = LW'(DATA_W);
    else                      nd = LW'(cfg_i.len) + LW'(MIN_LEN);
    par_en  = (cfg_i.par == PAR_EVEN) || (cfg_i.par == PAR_ODD);
    par_bit = (cfg_i.par == PAR_ODD);
    for (int i = 0; i < DATA_W; i++) begin
      if (LW'(i) < nd) par_bit = par_bit ^ data_i[i];
    end
    frame_n    = '1;
    frame_n[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (LW'(i) < nd) frame_n[i+1] = data_i[i];
    end
    for (int i = 0; i <= DATA_W; i++) begin
      if (par_en && (LW'(i) == nd)) frame_n[i+1] = par_bit;
    end
    nbits = CNT_W'(nd) + CNT_W'(2) + CNT_W'(par_en) + CNT_W'(cfg_i.stop2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
      cfg_q   <= '0;
    end else if (load_i) begin
      frame_q <= frame_n;
      left_q  <= nbits;
      busy_q  <= 1'b1;
      cfg_q   <= cfg_i;
    end else if (bit_end_i) begin
      if (last_o) begin
        frame_q <= '1;
        left_q  <= '0;
        busy_q  <= 1'b0;
      end else begin
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        left_q  <= left_q - 1'b1;
      end
    end
  end

  assign last_o   = busy_q && (left_q == CNT_W'(1));
  assign txd_o    = frame_q[0];
  assign busy_o   = busy_q;
  assign sync_q_o = cfg_q.sync;
  assign pol_q_o  = cfg_q.pol;

  p_idle_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_o);

  p_start_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!txd_o && busy_o));

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !load_i) |=> $stable(cfg_q));

  p_txd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !bit_end_i && !load_i) |=> $stable(txd_o));

endmodule

// File: rtl/ser_tx_sclk.sv
module ser_tx_sclk (
  input  logic busy_i,
  input  logic sync_i,
  input  logic pol_q_i,
  input  logic pol_live_i,
  input  logic half_i,
  output logic sclk_o
);

  // first half of a bit sits at the change level, second half at the sample level
  assign sclk_o = busy_i ? (pol_q_i ^ (sync_i & ~half_i)) : pol_live_i;

endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ser_frame_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              sync_mode_i,
  input  logic              sclk_pol_i,
  input  logic [2:0]        len_code_i,
  input  logic [1:0]        parity_i,
  input  logic              stop2_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  output logic              sclk_o,
  output logic              busy_o
);

  tx_cfg_t cfg_in;
  logic    load, half, bit_end, last, sync_q, pol_q;

  assign cfg_in = '{sync: sync_mode_i, pol: sclk_pol_i, len: len_code_i,
                    par: par_mode_e'(parity_i), stop2: stop2_i};

  assign tx_ready_o = !busy_o || (last && bit_end);
  assign load       = tx_valid_i && tx_ready_o;

  ser_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_o),
    .restart_i (load),
    .div_i     (div_i),
    .half_o    (half),
    .bit_end_o (bit_end)
  );

  ser_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .data_i    (tx_data_i),
    .cfg_i     (cfg_in),
    .bit_end_i (bit_end),
    .txd_o     (txd_o),
    .busy_o    (busy_o),
    .last_o    (last),
    .sync_q_o  (sync_q),
    .pol_q_o   (pol_q)
  );

  ser_tx_sclk u_sclk (
    .busy_i     (busy_o),
    .sync_i     (sync_q),
    .pol_q_i    (pol_q),
    .pol_live_i (sclk_pol_i),
    .half_i     (half),
    .sclk_o     (sclk_o)
  );

  // R9: every data transition in a synchronous frame meets the change level
  p_edge_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sync_q && !$stable(txd_o)) |-> (sclk_o != pol_q));

  // R6: no acceptance while mid-frame
  p_no_mid_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_end) |-> !tx_ready_o);

endmodule

// File: tb/ser_frame_tx_test.sv
`timescale 1ns/1ps
module ser_frame_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_i = '0;
  logic       sync_i = 1'b0, pol_i = 1'b0, stop2_i = 1'b0, valid_i = 1'b0;
  logic [2:0] len_i = '0;
  logic [1:0] par_i = '0;
  logic [8:0] data_i = '0;
  logic       ready_o, txd_o, sclk_o, busy_o;

  always #10 clk = ~clk;

  ser_frame_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_i), .sync_mode_i(sync_i),
    .sclk_pol_i(pol_i), .len_code_i(len_i), .parity_i(par_i), .stop2_i(stop2_i),
    .tx_valid_i(valid_i), .tx_data_i(data_i), .tx_ready_o(ready_o),
    .txd_o(txd_o), .sclk_o(sclk_o), .busy_o(busy_o)
  );

  typedef struct {
    logic [12:0] bits;
    int n, nd, per;
    bit pe, sync, pol, b2b, scr;
  } item_t;

  item_t q[$];
  int  checks = 0, errors = 0;
  bit  in_frame = 0, done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // expected frame built from R1..R4
  task automatic build(input logic [8:0] d, input logic [2:0] len, input logic [1:0] par,
                       input logic st2, output item_t it);
    int  nd;
    bit  pe;
    logic p;
    nd = (len > 3'd4) ? 9 : int'(len) + 5;
    pe = (par == 2'd1) || (par == 2'd2);
    p  = (par == 2'd2);
    it.bits = '1;
    it.bits[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      it.bits[i+1] = d[i];
      p = p ^ d[i];
    end
    if (pe) it.bits[nd+1] = p;
    it.nd = nd;
    it.pe = pe;
    it.n  = 1 + nd + int'(pe) + 1 + int'(st2);
  endtask

  // driver: called at a negedge, returns at a negedge
  task automatic send(input logic [8:0] d, input logic [2:0] len, input logic [1:0] par,
                      input logic st2, input logic sy, input logic po,
                      input logic [7:0] dv, input bit scramble);
    item_t it;
    data_i = d; len_i = len; par_i = par; stop2_i = st2;
    sync_i = sy; pol_i = po; div_i = dv; valid_i = 1'b1;
    while (!ready_o) @(negedge clk);
    build(d, len, par, st2, it);
    it.per  = 2 * (int'(dv) + 1);
    it.sync = sy;
    it.pol  = po;
    it.b2b  = busy_o;
    it.scr  = scramble;
    q.push_back(it);
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    if (scramble) begin
      len_i = ~len; par_i = par ^ 2'd3; stop2_i = ~st2;
      sync_i = ~sy; pol_i = ~po; div_i = dv + 8'd2; data_i = ~d;
    end
  endtask

  function automatic string tag_of(item_t it, int k);
    if (it.scr) return "R8";
    if (k == 0) return "R1";
    if (k <= it.nd) return "R2";
    if (it.pe && k == it.nd + 1) return "R3";
    return "R4";
  endfunction

  // monitor / scoreboard
  initial begin : mon
    item_t it;
    int gap, act;
    bit ok, ok_s, ok_b, ok_r, ex_s, ex_r;
    @(posedge rst_n);
    forever begin
      if (q.size() == 0) begin
        @(negedge clk);
        continue;
      end
      it = q.pop_front();
      in_frame = 1;
      gap = 0;
      while (txd_o !== 1'b0) begin
        @(negedge clk);
        gap++;
      end
      if (it.b2b) chk(gap == 0, "R5", "idle gap before back-to-back frame", gap, 0);
      ok_s = 1; ok_b = 1; ok_r = 1;
      for (int k = 0; k < it.n; k++) begin
        ok = 1;
        act = int'(it.bits[k]);
        for (int off = 0; off < it.per; off++) begin
          if (txd_o !== it.bits[k]) begin
            ok = 0;
            act = int'(txd_o);
          end
          ex_s = (it.sync && off < it.per / 2) ? !it.pol : it.pol;
          if (sclk_o !== ex_s) ok_s = 0;
          if (busy_o !== 1'b1) ok_b = 0;
          ex_r = (k == it.n - 1) && (off == it.per - 1);
          if (ready_o !== ex_r) ok_r = 0;
          @(negedge clk);
        end
        chk(ok, tag_of(it, k), $sformatf("bit %0d held 2*(div+1) cycles (R7)", k),
            act, int'(it.bits[k]));
      end
      chk(ok_s, it.sync ? "R9" : "R10", "shift clock level within frame", int'(ok_s), 1);
      chk(ok_b, "R11", "busy during frame", int'(ok_b), 1);
      chk(ok_r, "R6", "ready only in final stop cycle", int'(ok_r), 1);
      if (!(q.size() > 0 && q[0].b2b)) begin
        chk(busy_o === 1'b0, "R11", "busy after frame", int'(busy_o), 0);
        chk(txd_o === 1'b1, "R5", "line high after frame", int'(txd_o), 1);
      end
      in_frame = 0;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic drain();
    @(negedge clk);
    while (q.size() != 0 || in_frame) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd_o === 1'b1, "R5", "reset line level", int'(txd_o), 1);
    chk(busy_o === 1'b0, "R11", "reset busy", int'(busy_o), 0);
    chk(ready_o === 1'b1, "R6", "reset ready", int'(ready_o), 1);
    chk(sclk_o === 1'b0, "R10", "reset sclk at polarity 0", int'(sclk_o), 0);

    // R2 R4: 8 bits, no parity, one stop
    send(9'h0A5, 3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 8'd1, 0);
    drain();
    // R2 R3: every length with even parity, div 0
    for (int l = 0; l < 5; l++) begin
      send(9'h1B3, 3'(l), 2'd1, 1'b0, 1'b0, 1'b0, 8'd0, 0);
      drain();
    end
    // R3 R4: odd parity, 7 bits, two stops
    send(9'h055, 3'd2, 2'd2, 1'b1, 1'b0, 1'b0, 8'd2, 0);
    drain();
    send(9'h000, 3'd0, 2'd2, 1'b1, 1'b0, 1'b1, 8'd1, 0);
    drain();
    // R2 R3: out-of-range length code and parity code 3
    send(9'h12C, 3'd6, 2'd3, 1'b0, 1'b0, 1'b0, 8'd1, 0);
    drain();
    // R5 R6: back-to-back stream
    send(9'h0F0, 3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 8'd1, 0);
    send(9'h00F, 3'd1, 2'd2, 1'b1, 1'b0, 1'b0, 8'd1, 0);
    send(9'h1FF, 3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 8'd0, 0);
    drain();
    // R8: configuration scrambled right after acceptance
    send(9'h09C, 3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 8'd1, 1);
    drain();
    send(9'h163, 3'd2, 2'd0, 1'b1, 1'b1, 1'b1, 8'd2, 1);
    drain();
    // R9: synchronous mode, both polarities
    send(9'h0C3, 3'd3, 2'd1, 1'b0, 1'b1, 1'b0, 8'd2, 0);
    drain();
    send(9'h13A, 3'd4, 2'd2, 1'b1, 1'b1, 1'b1, 8'd1, 0);
    send(9'h005, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 8'd1, 0);
    drain();
    // R10: idle shift clock follows polarity input
    sync_i = 1'b1;
    pol_i  = 1'b1;
    @(negedge clk);
    chk(sclk_o === 1'b1, "R10", "idle sclk with polarity 1", int'(sclk_o), 1);
    pol_i = 1'b0;
    @(negedge clk);
    chk(sclk_o === 1'b0, "R10", "idle sclk with polarity 0", int'(sclk_o), 0);
    chk(txd_o === 1'b1, "R5", "idle line in synchronous mode", int'(txd_o), 1);
    finish_run();
  end

endmodule